// File: doc/BRIEF.md
# Two-Output A/V Routing Switch Serial Control Port

This block is the serial control and status port of a switch that routes six audio/video sources to two outputs. It is a target on an I2C bus running at standard-mode rates (SCL up to 100 kHz), sampled on a much faster system clock. A bus controller writes a two-byte control frame. The block decodes that frame into per-output source selects, mute flags, a luma/chroma path enable, an output-1 audio attenuation flag and a one-hot DC level select. A read returns one or two status bytes. These bytes are assembled from per-input detector flags: a "plug grounded" flag and a two-bit aspect level.

The 7-bit target address is `100100` followed by the `addr_sel` pin, so the write addresses are 90h and 92h. Output 1 has separate video and audio selectors. Output 2 has one selector that switches its video and audio together. The control registers change only after the second control byte has been acknowledged, so every field of a frame takes effect in the same cycle.

Top module: `avsw_i2c_ctrl`

## Requirements
- R1: After reset the decoded state is as if both control bytes were zero. Every output is muted, its source vector is zero and its luma/chroma enable is low, `o1_atten` is 0, `dc_lvl` is 3'b100 (high level), and SDA is not driven.
- R2: The block acknowledges only an address byte whose upper seven bits equal `100100` followed by `addr_sel`. Bit 0 of the address byte is 0 for a write and 1 for a read. Any other address gets no ACK and no SDA drive until the next START, and leaves the controls unchanged.
- R3: Control byte 1 and control byte 2 take effect together, on the SCL fall that ends the ACK of byte 2. A frame that ends after byte 1 changes nothing.
- R4: Each 3-bit select code decodes as follows: 0 and 7 mean mute with a zero source vector. 1 selects TV, which is one-hot bit 0. Codes 2 to 6 select inputs 1 to 5, which are one-hot bits 1 to 5. The output-1 video select is in byte-1 bits 5:3, and the output-1 audio select is in byte-1 bits 2:0.
- R5: Byte-2 bits 5:3 form one select that drives `o2_src`/`o2_mute`, and these two ports serve both the video and the audio path of output 2.
- R6: A luma/chroma enable is high only when its mode bit is 1 and the selected source is input 1 to 4. The mode bit is byte-1 bit 6 for output 1 and byte-2 bit 6 for output 2.
- R7: Byte-1 bit 7 drives `o1_atten`, where 1 means −6 dB on output-1 audio.
- R8: Byte-2 bits 2:1 pick `dc_lvl` as follows: code 1 gives 3'b001 (zero), code 2 gives 3'b010 (mid), and codes 0 and 3 give 3'b100 (high).
- R9: A read returns status byte 1 and then status byte 2, MSB first. In both bytes, bits 7:4 are the grounded flags of inputs 1, 2, 3 and 4. Byte 1 bits 3:2 and 1:0 hold the aspect codes of inputs 1 and 2. Byte 2 bits 3:2 and 1:0 hold the aspect codes of inputs 3 and 4.
- R10: The aspect code of an input reads 3 whenever its grounded flag is 0, whatever its level input says.
- R11: After the controller answers a status byte with NACK, the block does not drive SDA again until a new START. A STOP always releases SDA.
- R12: The block changes what it drives on SDA only while SCL is low.
- R13: A third data byte in a write frame gets no ACK and does not alter the controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| addr_sel | input | 1 | Address LSB select (0 gives 90h, 1 gives 92h) |
| det_grounded | input | 4 | Per-input plug-grounded flag, bit k-1 for input k |
| aspect_lvl | input | 8 | Per-input aspect level, bits 2k-1:2k-2 for input k |
| o1_vsrc | output | 6 | Output-1 video source, one-hot (bit 0 TV, bit k input k) |
| o1_vmute | output | 1 | Output-1 video muted |
| o1_ysep | output | 1 | Output-1 luma/chroma path enable |
| o1_asrc | output | 6 | Output-1 audio source, one-hot |
| o1_amute | output | 1 | Output-1 audio muted |
| o1_atten | output | 1 | Output-1 audio −6 dB |
| o2_src | output | 6 | Output-2 shared video/audio source, one-hot |
| o2_mute | output | 1 | Output-2 muted |
| o2_ysep | output | 1 | Output-2 luma/chroma path enable |
| dc_lvl | output | 3 | One-hot DC level: bit 0 zero, bit 1 mid, bit 2 high |

## Verification
On every cycle the assertions check the following. SDA is pulled low only while SCL is low. A STOP leaves SDA released. The decoded outputs change only on an SCL fall. Each mute flag agrees with an empty source vector, source vectors are at most one-hot, a luma/chroma enable implies input 1 to 4 is selected, and the DC select is exactly one-hot. Only the bench scenarios can show the rest: address matching on both pin settings, the atomic two-byte commit and the ignored partial or over-long frames, the exact status byte layout with its forced no-signal code, and the silence after a NACK.

// File: rtl/avsw_i2c_ctrl.sv
module avsw_i2c_ctrl #(
  parameter logic [5:0] ADDR_HI = 6'b100100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_drive_low,
  input  logic       addr_sel,
  input  logic [3:0] det_grounded,
  input  logic [7:0] aspect_lvl,
  output logic [5:0] o1_vsrc,
  output logic       o1_vmute,
  output logic       o1_ysep,
  output logic [5:0] o1_asrc,
  output logic       o1_amute,
  output logic       o1_atten,
  output logic [5:0] o2_src,
  output logic       o2_mute,
  output logic       o2_ysep,
  output logic [2:0] dc_lvl
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACKW, S_ACKD, S_TX, S_TACK} st_t;

  logic [1:0] scl_ff, sda_ff;
  logic       scl_s, sda_s, scl_q, sda_q;
  st_t        st;
  logic [7:0] sh;
  logic [3:0] bits;
  logic [1:0] idx;
  logic       rw, mack;
  logic [7:0] d1_t, ctl1;
  logic [5:0] d2_t, ctl2;
  logic [1:0] asp [4];

  assign scl_s = scl_ff[1];
  assign sda_s = sda_ff[1];

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] rx_byte = {sh[6:0], sda_s};

  for (genvar g = 0; g < 4; g++) begin : g_asp
    assign asp[g] = det_grounded[g] ? aspect_lvl[2*g +: 2] : 2'b11;
  end

  wire [7:0] stat1 = {det_grounded[0], det_grounded[1], det_grounded[2], det_grounded[3], asp[0], asp[1]};
  wire [7:0] stat2 = {det_grounded[0], det_grounded[1], det_grounded[2], det_grounded[3], asp[2], asp[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11; sda_ff <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      st <= S_IDLE; sh <= '0; bits <= '0; idx <= '0; rw <= 1'b0; mack <= 1'b0;
      d1_t <= '0; d2_t <= '0; ctl1 <= '0; ctl2 <= '0; sda_drive_low <= 1'b0;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      if (start_c) begin
        st <= S_RX; idx <= '0; bits <= '0; sda_drive_low <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_drive_low <= 1'b0;
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            sh   <= rx_byte;
            bits <= bits + 4'd1;
            if (bits == 4'd7) begin
              bits <= '0;
              if (idx == 2'd0) begin
                if (rx_byte[7:1] == {ADDR_HI, addr_sel}) begin
                  rw <= rx_byte[0];
                  st <= S_ACKW;
                end else st <= S_IDLE;
              end else if (idx == 2'd1) begin
                d1_t <= rx_byte; st <= S_ACKW;
              end else if (idx == 2'd2) begin
                d2_t <= rx_byte[6:1]; st <= S_ACKW;
              end else st <= S_IDLE;
            end
          end
          S_ACKW: if (scl_fall) begin
            sda_drive_low <= 1'b1; st <= S_ACKD;
          end
          S_ACKD: if (scl_fall) begin
            if (idx == 2'd0 && rw) begin
              sh <= {stat1[6:0], 1'b0}; sda_drive_low <= ~stat1[7];
              bits <= '0; idx <= 2'd1; st <= S_TX;
            end else begin
              sda_drive_low <= 1'b0;
              if (idx == 2'd2) begin
                ctl1 <= d1_t; ctl2 <= d2_t;
              end
              idx <= idx + 2'd1; st <= S_RX;
            end
          end
          S_TX: begin
            if (scl_rise) bits <= bits + 4'd1;
            if (scl_fall) begin
              if (bits == 4'd8) begin
                sda_drive_low <= 1'b0; st <= S_TACK;
              end else begin
                sda_drive_low <= ~sh[7]; sh <= {sh[6:0], 1'b0};
              end
            end
          end
          S_TACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack && idx == 2'd1) begin
                sh <= {stat2[6:0], 1'b0}; sda_drive_low <= ~stat2[7];
                bits <= '0; idx <= 2'd2; st <= S_TX;
              end else st <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  wire [2:0] v1c = ctl1[5:3];
  wire [2:0] a1c = ctl1[2:0];
  wire [2:0] c2  = ctl2[4:2];

  assign o1_vmute = (v1c == 3'd0) || (v1c == 3'd7);
  assign o1_amute = (a1c == 3'd0) || (a1c == 3'd7);
  assign o2_mute  = (c2 == 3'd0) || (c2 == 3'd7);
  assign o1_vsrc  = o1_vmute ? 6'd0 : 6'd1 << (v1c - 3'd1);
  assign o1_asrc  = o1_amute ? 6'd0 : 6'd1 << (a1c - 3'd1);
  assign o2_src   = o2_mute  ? 6'd0 : 6'd1 << (c2 - 3'd1);
  assign o1_ysep  = ctl1[6] && v1c >= 3'd2 && v1c <= 3'd5;
  assign o2_ysep  = ctl2[5] && c2 >= 3'd2 && c2 <= 3'd5;
  assign o1_atten = ctl1[7];
  assign dc_lvl   = (ctl2[1:0] == 2'd1) ? 3'b001 :
                    (ctl2[1:0] == 2'd2) ? 3'b010 : 3'b100;
endmodule

// File: rtl/avsw_i2c_ctrl_chk.sv
module avsw_i2c_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_q,
  input logic       sda_s,
  input logic       sda_q,
  input logic       sda_drive_low,
  input logic [5:0] o1_vsrc,
  input logic       o1_vmute,
  input logic       o1_ysep,
  input logic [5:0] o1_asrc,
  input logic       o1_amute,
  input logic       o1_atten,
  input logic [5:0] o2_src,
  input logic       o2_mute,
  input logic       o2_ysep,
  input logic [2:0] dc_lvl
);
  p_drive_low_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_s);

  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scl_s && scl_q && !sda_q && sda_s) |-> !sda_drive_low);

  p_commit_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(o1_vsrc) || !$stable(o1_asrc) || !$stable(o2_src) || !$stable(dc_lvl) || !$stable(o1_atten))
      |-> ($past(scl_q) && !$past(scl_s)));

  p_vmute_r4: assert property (@(posedge clk) disable iff (!rst_n)
    o1_vmute == (o1_vsrc == 6'd0));

  p_amute_r4: assert property (@(posedge clk) disable iff (!rst_n)
    o1_amute == (o1_asrc == 6'd0));

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(o1_vsrc) && $onehot0(o1_asrc));

  p_shared_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(o2_src) && (o2_mute == (o2_src == 6'd0)));

  p_ysep1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    o1_ysep |-> (o1_vsrc[4:1] != 4'd0));

  p_ysep2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    o2_ysep |-> (o2_src[4:1] != 4'd0));

  p_dc_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dc_lvl) == 1);
endmodule

bind avsw_i2c_ctrl avsw_i2c_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_q(scl_q), .sda_s(sda_s), .sda_q(sda_q),
  .sda_drive_low(sda_drive_low), .o1_vsrc(o1_vsrc), .o1_vmute(o1_vmute), .o1_ysep(o1_ysep),
  .o1_asrc(o1_asrc), .o1_amute(o1_amute), .o1_atten(o1_atten), .o2_src(o2_src),
  .o2_mute(o2_mute), .o2_ysep(o2_ysep), .dc_lvl(dc_lvl)
);

// File: tb/avsw_i2c_ctrl_bench.sv
`timescale 1ns/1ps
module avsw_i2c_ctrl_bench;
  localparam int HP = 16;
  localparam int NV = 6;
  localparam logic [7:0] D1 [NV] = '{8'h0A, 8'hDF, 8'h70, 8'h3E, 8'h6C, 8'h53};
  localparam logic [7:0] D2 [NV] = '{8'h32, 8'hED, 8'h4E, 8'h00, 8'h22, 8'h58};
  localparam logic [26:0] EX [NV] = '{
    {6'b000001,1'b0,6'b000010,1'b0,1'b0,1'b0,6'b100000,1'b0,1'b0,3'b001},
    {6'b000100,1'b0,6'b000000,1'b1,1'b1,1'b1,6'b010000,1'b0,1'b1,3'b010},
    {6'b100000,1'b0,6'b000000,1'b1,1'b0,1'b0,6'b000001,1'b0,1'b0,3'b100},
    {6'b000000,1'b1,6'b100000,1'b0,1'b0,1'b0,6'b000000,1'b1,1'b0,3'b100},
    {6'b010000,1'b0,6'b001000,1'b0,1'b1,1'b0,6'b001000,1'b0,1'b0,3'b001},
    {6'b000010,1'b0,6'b000100,1'b0,1'b1,1'b0,6'b000100,1'b0,1'b1,3'b100}};
  localparam logic [26:0] EX_RST = {6'b0,1'b1,6'b0,1'b1,1'b0,1'b0,6'b0,1'b1,1'b0,3'b100};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic [3:0] det = 4'b0;
  logic [7:0] lvl = 8'b0;
  logic sda_drive_low, o1_vmute, o1_ysep, o1_amute, o1_atten, o2_mute, o2_ysep;
  logic [5:0] o1_vsrc, o1_asrc, o2_src;
  logic [2:0] dc_lvl;
  wire sda_line = sda_m & ~sda_drive_low;
  wire [26:0] obs = {o1_vsrc, o1_vmute, o1_asrc, o1_amute, o1_ysep, o1_atten, o2_src, o2_mute, o2_ysep, dc_lvl};

  int n_run = 0, n_fail = 0, glitches = 0;
  logic drv_seen = 1'b0, done = 1'b0;

  avsw_i2c_ctrl u_avsw_i2c_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_drive_low(sda_drive_low),
    .addr_sel(addr_sel), .det_grounded(det), .aspect_lvl(lvl),
    .o1_vsrc(o1_vsrc), .o1_vmute(o1_vmute), .o1_ysep(o1_ysep), .o1_asrc(o1_asrc),
    .o1_amute(o1_amute), .o1_atten(o1_atten), .o2_src(o2_src), .o2_mute(o2_mute),
    .o2_ysep(o2_ysep), .dc_lvl(dc_lvl));

  always @(negedge clk) if (sda_drive_low) drv_seen = 1'b1;

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; hold(HP);
    sda_m = 1'b0; hold(HP);
    scl_m = 1'b0; hold(4);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hold(HP);
    scl_m = 1'b1; hold(HP);
    sda_m = 1'b1; hold(HP);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(HP);
      scl_m = 1'b1; hold(HP);
      scl_m = 1'b0; hold(4);
    end
    sda_m = 1'b1; hold(HP);
    scl_m = 1'b1; hold(HP/2);
    ack = ~sda_line; hold(HP/2);
    scl_m = 1'b0; hold(4);
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(HP);
      scl_m = 1'b1; hold(2);
      b[i] = sda_line; hold(HP-3);
      if (sda_line !== b[i]) glitches++;
      hold(1);
      scl_m = 1'b0; hold(4);
    end
    sda_m = ~give_ack; hold(HP);
    scl_m = 1'b1; hold(HP);
    scl_m = 1'b0; hold(4);
    sda_m = 1'b1;
  endtask

  task automatic wr_frame(input logic [7:0] a, input logic [7:0] d1, input logic [7:0] d2, output logic [2:0] acks);
    logic k;
    i2c_start();
    wr_byte(a, k);  acks[2] = k;
    wr_byte(d1, k); acks[1] = k;
    wr_byte(d2, k); acks[0] = k;
    i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] rb;
    logic k;
    hold(5);
    // R1 reset state
    chk("R1 outputs", 32'(obs), 32'(EX_RST));
    chk("R1 sda", 32'(sda_drive_low), 32'd0);
    rst_n = 1'b1; hold(5);
    chk("R1 after release", 32'(obs), 32'(EX_RST));

    // R2 R4 R5 R6 R7 R8 table walk
    for (int v = 0; v < NV; v++) begin
      wr_frame(8'h90, D1[v], D2[v], acks);
      chk("R2 acks", 32'(acks), 32'b111);
      chk("R4 R5 R6 R7 R8 decode", 32'(obs), 32'(EX[v]));
    end

    // R3 partial frame and atomic commit
    i2c_start();
    wr_byte(8'h90, k);
    wr_byte(8'h0A, k);
    chk("R3 mid-frame unchanged", 32'(obs), 32'(EX[5]));
    i2c_stop();
    chk("R3 partial ignored", 32'(obs), 32'(EX[5]));
    i2c_start();
    wr_byte(8'h90, k);
    wr_byte(D1[1], k);
    chk("R3 before byte2", 32'(obs), 32'(EX[5]));
    wr_byte(D2[1], k);
    chk("R3 both bytes at once", 32'(obs), 32'(EX[1]));
    i2c_stop();

    // R2 wrong address
    drv_seen = 1'b0;
    wr_frame(8'h92, D1[0], D2[0], acks);
    chk("R2 foreign address acks", 32'(acks), 32'b000);
    chk("R2 foreign address no drive", 32'(drv_seen), 32'd0);
    chk("R2 foreign address unchanged", 32'(obs), 32'(EX[1]));
    addr_sel = 1'b1;
    wr_frame(8'h90, D1[2], D2[2], acks);
    chk("R2 pin-high ignores 90h", 32'(acks), 32'b000);
    wr_frame(8'h92, D1[0], D2[0], acks);
    chk("R2 pin-high accepts 92h", 32'(acks), 32'b111);
    chk("R2 pin-high decode", 32'(obs), 32'(EX[0]));

    // R13 over-long frame
    i2c_start();
    wr_byte(8'h92, k);
    wr_byte(D1[4], k);
    wr_byte(D2[4], k);
    wr_byte(D1[3], k);
    chk("R13 third byte nack", 32'(k), 32'd0);
    i2c_stop();
    chk("R13 controls from bytes 1-2", 32'(obs), 32'(EX[4]));

    // R9 R10 two-byte status read
    det = 4'b1011;
    lvl = {2'd2, 2'd1, 2'd0, 2'd1};
    i2c_start();
    wr_byte(8'h93, k);
    chk("R2 read address ack", 32'(k), 32'd1);
    rd_byte(1'b1, rb);
    chk("R9 status byte 1", 32'(rb), 32'hD4);
    rd_byte(1'b0, rb);
    chk("R9 R10 status byte 2", 32'(rb), 32'hDE);
    i2c_stop();

    // R10 R11 single-byte read then silence
    det = 4'b0000;
    lvl = 8'h00;
    addr_sel = 1'b0;
    i2c_start();
    wr_byte(8'h91, k);
    rd_byte(1'b0, rb);
    chk("R10 all open", 32'(rb), 32'h0F);
    drv_seen = 1'b0;
    rd_byte(1'b0, rb);
    chk("R11 line idle after nack", 32'(rb), 32'hFF);
    chk("R11 no drive after nack", 32'(drv_seen), 32'd0);
    i2c_stop();
    chk("R11 released after stop", 32'(sda_drive_low), 32'd0);
    chk("R12 data stable while SCL high", 32'(glitches), 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule